// File: doc/BRIEF.md
# Page-Mode EEPROM Write-Cycle Sequencer

This block sits on the device side of a byte-wide, strobe-driven memory port. It follows the behaviour of a page-programmed non-volatile memory. A host loads bytes with chip-enable and write-enable strobes. The first accepted load of a sequence captures the page part of the address. Every later load of that sequence lands in the same page, and the low address bits choose a slot in a page buffer. When the host stops loading for a set number of clock cycles, the buffered bytes are committed to the storage array as a single programming operation.

During programming the block pulls its ready/busy line low. A read during programming does not return array data; it returns a status byte the host can poll. A device-reset input aborts whatever is in progress and releases both the data bus and the ready/busy line. After the reset is released, reads stay blocked for a short recovery time.

All strobes are active low and are sampled on the clock. The strobe port is not a valid/ready stream and has no back-pressure. A load offered while programming is dropped, so the host must poll the status byte or the busy line before loading again. The tri-state data bus and the open-drain busy line are shown as enables: `dout_en` and `busy_pull`. Window, programming and recovery times are parameters in clock cycles: `WIN_CYC`, `PROG_CYC` and `RCV_CYC`.

Top module: `pgwr_seq`

## Requirements
- R1: The first load of a sequence (a load accepted while idle) latches `addr[ADDR_W-1:6]` as the page. Every load of the sequence stores into the slot chosen by `addr[5:0]` of that load. Page bits offered on later loads are ignored.
- R2: Programming starts when `WIN_CYC` clock edges pass after the last accepted load with no further load. `busy_pull` becomes 1 after the `WIN_CYC`-th rising edge that follows the load edge.
- R3: A programming operation lasts `PROG_CYC` clock cycles and then the block returns to ready. Afterwards every loaded byte reads back from its array location.
- R4: A read condition is `ce_n`=0, `oe_n`=0, `we_n`=1 with `hold_n`=1 and recovery over. It sets `dout_en` after the next rising edge. While ready, `dout` then holds the array byte at the address sampled on that edge.
- R5: `busy_pull` is 1 exactly while programming and is 0 when idle, when loading, and whenever `hold_n` is 0.
- R6: A read during programming returns status instead of data. Bit 7 is the complement of bit 7 of the last accepted load, and bits 5 to 0 read 0.
- R7: During programming, bit 6 of the status flips at the start of every read. It is 0 when programming begins, so the first read shows 1, the next 0, and so on.
- R8: While `hold_n` is 0, `dout_en` and `busy_pull` are 0, no load is accepted, and any load sequence or programming is abandoned: uncommitted bytes are discarded and no programming follows. After `hold_n` returns to 1, reads stay blocked for `RCV_CYC` edges.
- R9: A load is accepted only on the first clock edge where `ce_n`=0, `we_n`=0 and `oe_n`=1. A strobe with `oe_n`=0, or any load during programming, changes nothing.
- R10: Page-buffer slots not loaded in a sequence leave their array locations unchanged.
- R11: Holding the write strobes low across many cycles makes a single load, using the data present on its first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| arst_n | input | 1 | Asynchronous system reset, active low |
| hold_n | input | 1 | Device reset: aborts activity and floats outputs when low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address; upper bits are the page, lower 6 the slot |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or polling status |
| dout_en | output | 1 | Data bus drive enable (0 means high impedance) |
| busy_pull | output | 1 | 1 drives the open-drain ready/busy line low |

## Verification
The hardest states to reach from the ports are a device reset that lands in the middle of a load window, and one that lands after programming has committed its bytes but before it ends. The stimulus handles the first case by loading one byte, then dropping `hold_n` with the read strobes already active. It then releases `hold_n` and checks that reads stay blocked and that no programming ever follows. For the second case it waits a fixed count past the start of busy, so that every slot has been written, then aborts. It checks that busy falls at once and that the committed byte survives. A behavioural model in the bench follows every edge and compares the outputs on every cycle. Directed reads then confirm the page latch, untouched slots, ignored writes and the toggle order of status bit 6.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } seq_state_e;

  localparam int BYTE_W = 8;
  localparam int SLOT_W = 6;
endpackage

// File: rtl/pgwr_strobe.sv
module pgwr_strobe #(
  parameter int RCV_CYC = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic hold_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic load_ev,
  output logic rd_start,
  output logic rd_q
);
  localparam int RW = $clog2(RCV_CYC + 1);

  logic [RW-1:0] rcv_cnt;
  logic          wr_cond;
  logic          wr_q;
  logic          rd_cond;

  // a write needs output-enable released; reads need recovery over
  assign wr_cond  = hold_n & ~ce_n & ~we_n & oe_n;
  assign rd_cond  = hold_n & (rcv_cnt == '0) & ~ce_n & ~oe_n & we_n;
  assign load_ev  = wr_cond & ~wr_q;
  assign rd_start = rd_cond & ~rd_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
      rcv_cnt <= '0;
    end else begin
      wr_q <= wr_cond;
      rd_q <= rd_cond;
      if (!hold_n)
        rcv_cnt <= RW'(RCV_CYC);
      else if (rcv_cnt != '0)
        rcv_cnt <= rcv_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/pgwr_pagebuf.sv
module pgwr_pagebuf #(
  parameter int IDX_W = 6,
  parameter int PG_W  = 3,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             clr,
  input  logic             store,
  input  logic             pg_ld,
  input  logic [PG_W-1:0]  pg_in,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic             rd_vld,
  output logic [PG_W-1:0]  page_q
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0]    slot_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit;
    assign hit = store && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)
        vld_q[g] <= 1'b0;
      else if (clr)
        vld_q[g] <= 1'b0;
      else if (hit)
        vld_q[g] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit)
        slot_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)
      page_q <= '0;
    else if (pg_ld)
      page_q <= pg_in;
  end

  assign rd_data = slot_q[rd_idx];
  assign rd_vld  = vld_q[rd_idx];
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int WIN_CYC  = 200,
  parameter int PROG_CYC = 400,
  parameter int CNT_W    = 9
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             hold_n,
  input  logic             load_ev,
  input  logic             rd_start,
  input  logic             din7,
  output logic             st_busy,
  output logic             load_acc,
  output logic             pg_ld,
  output logic             buf_clr,
  output logic             commit_act,
  output logic [IDX_W-1:0] commit_idx,
  output logic             tog_q,
  output logic             last7_q
);
  localparam int DEPTH = 1 << IDX_W;

  seq_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             prog_end;

  assign st_busy    = (st_q == ST_PROG);
  assign load_acc   = load_ev && !st_busy;
  assign pg_ld      = load_acc && (st_q == ST_IDLE);
  assign prog_end   = st_busy && (cnt_q == CNT_W'(PROG_CYC - 1));
  assign buf_clr    = !hold_n || prog_end;
  // one slot per cycle during the first DEPTH cycles of programming
  assign commit_act = st_busy && hold_n && (cnt_q < CNT_W'(DEPTH));
  assign commit_idx = cnt_q[IDX_W-1:0];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      tog_q   <= 1'b0;
      last7_q <= 1'b0;
    end else if (!hold_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      if (load_acc)
        last7_q <= din7;
      case (st_q)
        ST_IDLE: begin
          if (load_acc) begin
            st_q  <= ST_LOAD;
            cnt_q <= '0;
          end
        end
        ST_LOAD: begin
          if (load_acc) begin
            cnt_q <= '0;
          end else if (cnt_q == CNT_W'(WIN_CYC - 1)) begin
            st_q  <= ST_PROG;
            cnt_q <= '0;
            tog_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PROG: begin
          if (rd_start)
            tog_q <= ~tog_q;
          if (prog_end) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          st_q  <= ST_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/pgwr_ram.sv
module pgwr_ram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rq
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    rq <= mem[raddr];
  end
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
  import pgwr_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int WIN_CYC  = 200,
  parameter int PROG_CYC = 400,
  parameter int RCV_CYC  = 8
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              hold_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              busy_pull
);
  localparam int IDX_W   = SLOT_W;
  localparam int PG_W    = ADDR_W - IDX_W;
  localparam int CNT_MAX = (WIN_CYC > PROG_CYC) ? WIN_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             load_ev;
  logic             rd_start;
  logic             rd_q;
  logic             st_busy;
  logic             load_acc;
  logic             pg_ld;
  logic             buf_clr;
  logic             commit_act;
  logic [IDX_W-1:0] commit_idx;
  logic             tog_q;
  logic             last7_q;
  logic [7:0]       slot_data;
  logic             slot_vld;
  logic [PG_W-1:0]  page_q;
  logic [7:0]       ram_q;

  pgwr_strobe #(.RCV_CYC(RCV_CYC)) u_strobe (
    .clk      (clk),
    .arst_n   (arst_n),
    .hold_n   (hold_n),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .load_ev  (load_ev),
    .rd_start (rd_start),
    .rd_q     (rd_q)
  );

  pgwr_ctrl #(
    .IDX_W    (IDX_W),
    .WIN_CYC  (WIN_CYC),
    .PROG_CYC (PROG_CYC),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .arst_n     (arst_n),
    .hold_n     (hold_n),
    .load_ev    (load_ev),
    .rd_start   (rd_start),
    .din7       (din[7]),
    .st_busy    (st_busy),
    .load_acc   (load_acc),
    .pg_ld      (pg_ld),
    .buf_clr    (buf_clr),
    .commit_act (commit_act),
    .commit_idx (commit_idx),
    .tog_q      (tog_q),
    .last7_q    (last7_q)
  );

  pgwr_pagebuf #(.IDX_W(IDX_W), .PG_W(PG_W), .DW(BYTE_W)) u_buf (
    .clk     (clk),
    .arst_n  (arst_n),
    .clr     (buf_clr),
    .store   (load_acc),
    .pg_ld   (pg_ld),
    .pg_in   (addr[ADDR_W-1:IDX_W]),
    .wr_idx  (addr[IDX_W-1:0]),
    .wr_data (din),
    .rd_idx  (commit_idx),
    .rd_data (slot_data),
    .rd_vld  (slot_vld),
    .page_q  (page_q)
  );

  pgwr_ram #(.AW(ADDR_W), .DW(BYTE_W)) u_ram (
    .clk   (clk),
    .we    (commit_act && slot_vld),
    .waddr ({page_q, commit_idx}),
    .wdata (slot_data),
    .raddr (addr),
    .rq    (ram_q)
  );

  assign dout      = st_busy ? {~last7_q, tog_q, 6'b0} : ram_q;
  assign dout_en   = rd_q && hold_n;
  assign busy_pull = st_busy && hold_n;
endmodule

// File: rtl/pgwr_chk.sv
module pgwr_chk #(
  parameter int WIN_CYC  = 200,
  parameter int PROG_CYC = 400,
  parameter int RCV_CYC  = 8,
  parameter int PG_W     = 3
) (
  input logic            clk,
  input logic            arst_n,
  input logic            hold_n,
  input logic            load_acc,
  input logic            st_busy,
  input logic            busy_pull,
  input logic            dout_en,
  input logic [7:0]      dout,
  input logic [7:0]      din,
  input logic [PG_W-1:0] page_q
);
  logic [15:0] gap_q;
  logic [15:0] bcnt_q;
  logic [15:0] rel_q;
  logic        lastd7_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      gap_q    <= '0;
      bcnt_q   <= '0;
      rel_q    <= '1;
      lastd7_q <= 1'b0;
    end else begin
      if (load_acc)
        gap_q <= '0;
      else if (gap_q != '1)
        gap_q <= gap_q + 1'b1;
      if (load_acc)
        lastd7_q <= din[7];
      if (st_busy)
        bcnt_q <= (bcnt_q != '1) ? bcnt_q + 1'b1 : bcnt_q;
      else
        bcnt_q <= '0;
      if (!hold_n)
        rel_q <= '0;
      else if (rel_q != '1)
        rel_q <= rel_q + 1'b1;
    end
  end

  assert_window_R2: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(busy_pull) |-> (gap_q == 16'(WIN_CYC)));

  assert_prog_len_R3: assert property (@(posedge clk) disable iff (!arst_n)
    ($fell(st_busy) && $past(hold_n)) |-> (bcnt_q == 16'(PROG_CYC)));

  assert_poll_bit7_R6: assert property (@(posedge clk) disable iff (!arst_n)
    (busy_pull && dout_en) |-> ((dout[7] != lastd7_q) && (dout[5:0] == 6'd0)));

  assert_recovery_R8: assert property (@(posedge clk) disable iff (!arst_n)
    dout_en |-> (rel_q > 16'(RCV_CYC)));

  assert_page_hold_R1: assert property (@(posedge clk) disable iff (!arst_n)
    (st_busy && $past(st_busy)) |-> $stable(page_q));
endmodule

bind pgwr_seq pgwr_chk #(
  .WIN_CYC  (WIN_CYC),
  .PROG_CYC (PROG_CYC),
  .RCV_CYC  (RCV_CYC),
  .PG_W     (PG_W)
) u_chk (
  .clk       (clk),
  .arst_n    (arst_n),
  .hold_n    (hold_n),
  .load_acc  (load_acc),
  .st_busy   (st_busy),
  .busy_pull (busy_pull),
  .dout_en   (dout_en),
  .dout      (dout),
  .din       (din),
  .page_q    (page_q)
);

// File: tb/sim_pgwr_seq.sv
`timescale 1ns/1ps
module sim_pgwr_seq;
  localparam int AW   = 9;
  localparam int WIN  = 200;
  localparam int PROG = 400;
  localparam int RCV  = 8;

  logic          clk = 1'b0;
  logic          arst_n = 1'b0;
  logic          hold_n = 1'b1;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          dout_en;
  logic          busy_pull;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  pgwr_seq #(.ADDR_W(AW), .WIN_CYC(WIN), .PROG_CYC(PROG), .RCV_CYC(RCV)) u0 (
    .clk(clk), .arst_n(arst_n), .hold_n(hold_n), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .busy_pull(busy_pull)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         m_st = 0;      // 0 idle, 1 loading, 2 programming
  int         m_cnt = 0;
  int         m_page = 0;
  logic [7:0] m_buf [64];
  bit         m_val [64];
  logic [7:0] m_arr [1<<AW];
  bit         m_last7 = 0;
  bit         m_tog = 0;
  bit         m_wq = 0;
  bit         m_rq = 0;
  int         m_rcv = 0;
  logic [7:0] m_ramq = 'x;

  always @(posedge clk) begin
    cyc++;
    if (!arst_n) begin
      m_st = 0; m_cnt = 0; m_wq = 0; m_rq = 0; m_rcv = 0; m_tog = 0; m_last7 = 0;
      for (int i = 0; i < 64; i++) m_val[i] = 0;
    end else begin
      bit wr, rd, ld, rs;
      logic [7:0] nq;
      wr = hold_n && !ce_n && !we_n && oe_n;
      rd = hold_n && (m_rcv == 0) && !ce_n && !oe_n && we_n;
      ld = wr && !m_wq && (m_st != 2);
      rs = rd && !m_rq;
      nq = m_arr[addr];
      if (!hold_n) begin
        m_st = 0; m_cnt = 0;
        for (int i = 0; i < 64; i++) m_val[i] = 0;
      end else begin
        if (ld) begin
          if (m_st == 0) m_page = int'(addr[AW-1:6]);
          m_buf[addr[5:0]] = din;
          m_val[addr[5:0]] = 1;
          m_last7 = din[7];
        end
        if (m_st == 0) begin
          if (ld) begin m_st = 1; m_cnt = 0; end
        end else if (m_st == 1) begin
          if (ld) m_cnt = 0;
          else if (m_cnt == WIN - 1) begin m_st = 2; m_cnt = 0; m_tog = 0; end
          else m_cnt++;
        end else begin
          if (m_cnt < 64 && m_val[m_cnt]) m_arr[m_page * 64 + m_cnt] = m_buf[m_cnt];
          if (rs) m_tog = !m_tog;
          if (m_cnt == PROG - 1) begin
            m_st = 0; m_cnt = 0;
            for (int i = 0; i < 64; i++) m_val[i] = 0;
          end else m_cnt++;
        end
      end
      m_wq = wr;
      m_rq = rd;
      if (!hold_n) m_rcv = RCV;
      else if (m_rcv > 0) m_rcv--;
      m_ramq = nq;
    end
  end

  always @(negedge clk) begin
    if (arst_n) begin
      bit e_busy, e_en;
      logic [7:0] e_d;
      e_busy = (m_st == 2) && hold_n;
      e_en = m_rq && hold_n;
      e_d = (m_st == 2) ? {~m_last7, m_tog, 6'b0} : m_ramq;
      check(busy_pull == e_busy, "R5 busy line vs model", int'(busy_pull), int'(e_busy));
      check(dout_en == e_en, "R4 bus enable vs model", int'(dout_en), int'(e_en));
      if (e_en && !$isunknown(e_d))
        check(dout == e_d, (m_st == 2) ? "R6 status vs model" : "R4 data vs model",
              int'(dout), int'(e_d));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_write(input int a, input int d);
    @(negedge clk);
    addr = AW'(a); din = 8'(d); ce_n = 0; we_n = 0; oe_n = 1;
    @(negedge clk); @(negedge clk);
    ce_n = 1; we_n = 1;
    @(negedge clk);
  endtask

  task automatic do_read(input int a, output logic [7:0] d, output logic en);
    @(negedge clk);
    addr = AW'(a); ce_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk);
    d = dout; en = dout_en;
    ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic read_chk(input int a, input int exp, input string tag);
    logic [7:0] d; logic en;
    do_read(a, d, en);
    check(en === 1'b1, tag, int'(en), 1);
    check(d === 8'(exp), tag, int'(d), exp);
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (!busy_pull && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_ready();
    int n = 0;
    while (busy_pull && n < 5000) begin @(negedge clk); n++; end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    int n;
    logic [7:0] d; logic en;
    repeat (3) @(negedge clk);
    arst_n = 1;
    @(negedge clk);
    check(busy_pull == 0, "R5 reset busy", int'(busy_pull), 0);
    check(dout_en == 0, "R4 reset bus enable", int'(dout_en), 0);

    // sequence A: fill known contents, measure window and programming length
    do_write(9'h089, 8'h11);
    do_write(9'h08B, 8'h22);
    wait_busy(n);
    check(n == WIN - 2, "R2 window lapse to busy", n, WIN - 2);
    n = 0;
    while (busy_pull && n < 5000) begin @(negedge clk); n++; end
    check(n == PROG, "R3 programming length", n, PROG);

    // sequence B: page latch, polling status, write while busy
    do_write(9'h085, 8'hA5);
    do_write(9'h08A, 8'h3C);
    do_write(9'h1C7, 8'h77);          // page bits ignored: lands at 0x087
    wait_busy(n);
    do_read(9'h085, d, en);
    check(d[7] == 1'b1, "R6 status bit7 complement", int'(d[7]), 1);
    check(d[6] == 1'b1, "R7 first toggle", int'(d[6]), 1);
    do_read(9'h085, d, en);
    check(d[6] == 1'b0, "R7 second toggle", int'(d[6]), 0);
    do_read(9'h085, d, en);
    check(d[6] == 1'b1, "R7 third toggle", int'(d[6]), 1);
    do_write(9'h08B, 8'h55);          // dropped while busy
    wait_ready();
    read_chk(9'h085, 8'hA5, "R3 committed byte");
    read_chk(9'h08A, 8'h3C, "R3 rewritten byte");
    read_chk(9'h087, 8'h77, "R1 page latched on first load");
    read_chk(9'h089, 8'h11, "R10 unloaded slot kept");
    read_chk(9'h08B, 8'h22, "R9 load during busy ignored");

    // output-enable low during write strobe
    @(negedge clk);
    addr = 9'h08B; din = 8'h99; ce_n = 0; we_n = 0; oe_n = 0;
    repeat (3) @(negedge clk);
    ce_n = 1; we_n = 1; oe_n = 1;
    n = 0;
    repeat (WIN + 20) begin @(negedge clk); if (busy_pull) n++; end
    check(n == 0, "R9 oe-low write no program", n, 0);
    read_chk(9'h08B, 8'h22, "R9 oe-low write no change");

    // long strobe: single load with first-edge data
    @(negedge clk);
    addr = 9'h00C; din = 8'h5A; ce_n = 0; we_n = 0; oe_n = 1;
    repeat (5) @(negedge clk);
    din = 8'h6B;
    repeat (15) @(negedge clk);
    ce_n = 1; we_n = 1;
    do_write(9'h00D, 8'h01);
    wait_busy(n);
    wait_ready();
    read_chk(9'h00C, 8'h5A, "R11 held strobe single load");
    read_chk(9'h00D, 8'h01, "R1 page zero slot");

    // device reset during load window
    do_write(9'h00D, 8'hEE);
    @(negedge clk);
    hold_n = 0; addr = 9'h00D; ce_n = 0; oe_n = 0; we_n = 1;
    repeat (3) @(negedge clk);
    check(dout_en == 0, "R8 bus floats in hold", int'(dout_en), 0);
    check(busy_pull == 0, "R8 busy floats in hold", int'(busy_pull), 0);
    hold_n = 1;
    @(negedge clk);
    check(dout_en == 0, "R8 read blocked after release", int'(dout_en), 0);
    repeat (RCV + 3) @(negedge clk);
    check(dout_en == 1, "R8 read resumes after recovery", int'(dout_en), 1);
    ce_n = 1; oe_n = 1;
    n = 0;
    repeat (WIN + 20) begin @(negedge clk); if (busy_pull) n++; end
    check(n == 0, "R8 aborted sequence no program", n, 0);
    read_chk(9'h00D, 8'h01, "R8 aborted byte discarded");

    // device reset late in programming
    do_write(9'h020, 8'h44);
    wait_busy(n);
    repeat (100) @(negedge clk);
    hold_n = 0;
    @(negedge clk);
    check(busy_pull == 0, "R8 abort releases busy", int'(busy_pull), 0);
    @(negedge clk);
    hold_n = 1;
    repeat (RCV + 3) @(negedge clk);
    check(busy_pull == 0, "R5 no busy after abort", int'(busy_pull), 0);
    read_chk(9'h020, 8'h44, "R3 committed before abort");

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule